// File: doc/BRIEF.md
# Synchronous DRAM Command Front End with Bank Tracking

This block sits on the device side of a four-bank synchronous DRAM. It samples the control strobes, the address bus, the bank select and the clock enable on each rising clock edge. It turns them into one-cycle command pulses for activate, read, write, precharge, auto refresh and mode-register load. For every bank it tracks whether a row is open and which row it is. It also follows the burst that a read or write starts, so that an automatic close can be carried out when that burst ends.

Commands that break the bank protocol are rejected and reported on an error pulse, and they leave the state unchanged. When clock enable drops, the block freezes its internal state in a low-power mode. It enters self refresh instead if the command sampled on that edge is a legal refresh. The memory array, the data path, the analog timing and the refresh row counter are handled by other blocks.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted, every bank is closed, every command pulse and the error pulse are low, the burst is inactive, and both low-power outputs are low.
- R2: With chip select high (deselect), no command takes effect and no pulse is raised, but a burst already running keeps counting down to its end.
- R3: With chip select low, the strobe code {row, column, write} is decoded as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode load, and 111 is a no-operation. The matching pulse is high for the one cycle after the sampling edge, and at most one of the pulses and the error flag is high at a time.
- R4: An activate to a closed bank opens the bank named by the bank select and stores the full 13-bit address as that bank's open row.
- R5: A read or write to an open bank raises its pulse, presents the low 9 address bits as the column, and holds the burst active for BURST_LEN (default 4) cycles after the sampling edge.
- R6: Address bit 10 high on a read or write requests an automatic close. The addressed bank closes on the same edge on which its burst ends. With bit 10 low, the bank stays open.
- R7: A precharge with address bit 10 high closes all four banks. With bit 10 low, it closes only the selected bank.
- R8: A read or write to a closed bank, or an activate to an open bank, raises the error pulse, raises no command pulse, and changes no bank, row or burst state.
- R9: A refresh while any bank is open raises the error pulse and no refresh pulse.
- R10: Clock enable low at an edge enters power-down. While the block is in power-down, commands are ignored and the bank and burst state is frozen. Clock enable high at a later edge exits, and the command sampled on that exit edge is ignored.
- R11: Clock enable low on an edge that carries a refresh, with all banks closed, enters self refresh instead of power-down. If any bank is open, it enters power-down and raises the error pulse.
- R12: A read or write issued while a burst with a pending automatic close is still running raises the error pulse and does not disturb that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; low enters a low-power mode |
| chip_sel_n | input | 1 | Active-low chip select |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| wr_en_n | input | 1 | Active-low write strobe |
| adr | input | 13 | Row address, or column address plus close/all flag in bit 10 |
| bank_sel | input | 2 | Bank select |
| act_p | output | 1 | Activate accepted |
| rd_p | output | 1 | Read accepted |
| wr_p | output | 1 | Write accepted |
| pre_p | output | 1 | Precharge accepted |
| ref_p | output | 1 | Refresh accepted |
| mrs_p | output | 1 | Mode load accepted |
| err_p | output | 1 | Protocol violation pulse |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Open row per bank, bank b at bits [13b+12:13b] |
| burst_active | output | 1 | Burst in progress |
| burst_col | output | 9 | Start column of the current burst |
| burst_autopre | output | 1 | Current burst ends with an automatic close |
| low_power | output | 1 | In power-down or self refresh |
| self_refresh | output | 1 | In self refresh |

## Verification
The decode is driven with every strobe code under chip select low. The bench then repeats a code with chip select high, which separates a decoder that honours deselect from one that does not, and it watches the burst count run on during deselect. Reads and writes are sent to open and closed banks, with bit 10 both low and high. These patterns separate a plain burst end from an automatic close and show that rejected commands leave the state as it was. Clock enable is dropped with a no-operation, with an ignored activate, and with refresh both legal and illegal. This tells power-down from self refresh and shows that a burst freezes rather than ends while the clock is stopped.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clk_en,
  input  logic                           chip_sel_n,
  input  logic                           row_strobe_n,
  input  logic                           col_strobe_n,
  input  logic                           wr_en_n,
  input  logic [ROW_W-1:0]               adr,
  input  logic [BA_W-1:0]                bank_sel,
  output logic                           act_p,
  output logic                           rd_p,
  output logic                           wr_p,
  output logic                           pre_p,
  output logic                           ref_p,
  output logic                           mrs_p,
  output logic                           err_p,
  output logic [(1<<BA_W)-1:0]           bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0]     open_rows,
  output logic                           burst_active,
  output logic [COL_W-1:0]               burst_col,
  output logic                           burst_autopre,
  output logic                           low_power,
  output logic                           self_refresh
);
  localparam int NB    = 1 << BA_W;
  localparam int CNT_W = $clog2(BURST_LEN) + 1;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  logic [CNT_W-1:0] rem_q;
  logic [BA_W-1:0]  ap_bank_q;

  wire [2:0] code    = {row_strobe_n, col_strobe_n, wr_en_n};
  wire       run     = !low_power && clk_en;
  wire       sel     = run && !chip_sel_n;
  wire       is_act  = sel && code == C_ACT;
  wire       is_rd   = sel && code == C_RD;
  wire       is_wr   = sel && code == C_WR;
  wire       is_pre  = sel && code == C_PRE;
  wire       is_ref  = sel && code == C_REF;
  wire       is_mrs  = sel && code == C_MRS;
  wire       hit     = bank_open[bank_sel];
  wire       any_open = |bank_open;
  wire       ap_busy = burst_active && burst_autopre;
  wire       act_ok  = is_act && !hit;
  wire       rw_ok   = (is_rd || is_wr) && hit && !ap_busy;
  wire       ref_ok  = is_ref && !any_open;
  wire       enter   = !low_power && !clk_en;
  wire       ref_cmd = !chip_sel_n && code == C_REF;
  wire       enter_sr  = enter && ref_cmd && !any_open;
  wire       enter_bad = enter && ref_cmd && any_open;
  wire       burst_end = run && burst_active && rem_q == '0;
  wire       bad = (is_act && hit) || ((is_rd || is_wr) && (!hit || ap_busy))
                   || (is_ref && any_open) || enter_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {act_p, rd_p, wr_p, pre_p, ref_p, mrs_p, err_p} <= '0;
      low_power    <= 1'b0;
      self_refresh <= 1'b0;
    end else begin
      act_p <= act_ok;
      rd_p  <= is_rd && rw_ok;
      wr_p  <= is_wr && rw_ok;
      pre_p <= is_pre;
      ref_p <= ref_ok;
      mrs_p <= is_mrs;
      err_p <= bad;
      if (low_power) begin
        if (clk_en) begin
          low_power    <= 1'b0;
          self_refresh <= 1'b0;
        end
      end else if (!clk_en) begin
        low_power    <= 1'b1;
        self_refresh <= enter_sr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_active  <= 1'b0;
      burst_autopre <= 1'b0;
      burst_col     <= '0;
      rem_q         <= '0;
      ap_bank_q     <= '0;
    end else if (rw_ok) begin
      burst_active  <= 1'b1;
      burst_autopre <= adr[AP_BIT];
      burst_col     <= adr[COL_W-1:0];
      rem_q         <= CNT_W'(BURST_LEN - 1);
      ap_bank_q     <= bank_sel;
    end else if (burst_end) begin
      burst_active  <= 1'b0;
      burst_autopre <= 1'b0;
    end else if (run && burst_active) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    wire opens  = act_ok && bank_sel == BA_W'(b);
    wire closes = (is_pre && (adr[AP_BIT] || bank_sel == BA_W'(b)))
                  || (burst_end && burst_autopre && ap_bank_q == BA_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        open_rows[b*ROW_W +: ROW_W] <= '0;
      end else if (opens) begin
        bank_open[b] <= 1'b1;
        open_rows[b*ROW_W +: ROW_W] <= adr;
      end else if (closes) begin
        bank_open[b] <= 1'b0;
      end
    end
  end

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_p, rd_p, wr_p, pre_p, ref_p, mrs_p, err_p}));

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chip_sel_n) && !$past(low_power) && $past(clk_en)
      |-> !(act_p || rd_p || wr_p || pre_p || ref_p || mrs_p || err_p));

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_p |-> bank_open[$past(bank_sel)]);

  assert_rw_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_p || wr_p) |-> ((($past(bank_open) >> $past(bank_sel)) & 1) != 0)
                       && burst_active);

  assert_ref_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_p |-> $past(bank_open) == '0);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(low_power) |-> $stable(bank_open) && $stable(burst_active));

  assert_sr_needs_lp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh |-> low_power);
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b1, chip_sel_n = 1'b1;
  logic [2:0] code = 3'b111;
  logic [12:0] adr = '0;
  logic [1:0] bank_sel = '0;
  logic act_p, rd_p, wr_p, pre_p, ref_p, mrs_p, err_p;
  logic [3:0] bank_open;
  logic [51:0] open_rows;
  logic burst_active, burst_autopre, low_power, self_refresh;
  logic [8:0] burst_col;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, REF = 3'b001, MRS = 3'b000, NOP = 3'b111;
  localparam logic [5:0] P_ACT = 6'b100000, P_RD = 6'b010000, P_WR = 6'b001000,
                         P_PRE = 6'b000100, P_REF = 6'b000010, P_MRS = 6'b000001;
  localparam logic [12:0] A10 = 13'h0400;

  always #4 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
    .row_strobe_n(code[2]), .col_strobe_n(code[1]), .wr_en_n(code[0]),
    .adr(adr), .bank_sel(bank_sel),
    .act_p(act_p), .rd_p(rd_p), .wr_p(wr_p), .pre_p(pre_p), .ref_p(ref_p),
    .mrs_p(mrs_p), .err_p(err_p), .bank_open(bank_open), .open_rows(open_rows),
    .burst_active(burst_active), .burst_col(burst_col),
    .burst_autopre(burst_autopre), .low_power(low_power),
    .self_refresh(self_refresh));

  wire [5:0] pulses = {act_p, rd_p, wr_p, pre_p, ref_p, mrs_p};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic cs, input logic [2:0] c, input logic [1:0] b,
                       input logic [12:0] a, input logic ce = 1'b1);
    chip_sel_n = cs; code = c; bank_sel = b; adr = a; clk_en = ce;
    @(negedge clk);
  endtask

  task automatic nop();
    issue(1'b0, NOP, 2'd0, 13'd0);
  endtask

  task automatic close_all();
    issue(1'b0, PRE, 2'd0, A10);
    nop();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 pulses", {pulses, err_p}, 0);
    chk("R1 banks", bank_open, 0);
    chk("R1 burst", burst_active, 0);
    chk("R1 lowpower", {low_power, self_refresh}, 0);
    rst_n = 1'b1;
    nop();
  endtask

  task automatic t_decode();
    issue(1'b0, MRS, 2'd0, 13'h0032);  chk("R3 mode load", pulses, P_MRS);
    issue(1'b0, ACT, 2'd2, 13'h1ABC);  chk("R3 activate", pulses, P_ACT);
    chk("R4 open b2", bank_open, 4'b0100);
    chk("R4 row b2", open_rows[26 +: 13], 13'h1ABC);
    nop();                             chk("R3 nop", {pulses, err_p}, 0);
    issue(1'b0, ACT, 2'd0, 13'h0005);  chk("R4 open b0", bank_open, 4'b0101);
    chk("R4 row b0", open_rows[0 +: 13], 13'h0005);
    issue(1'b0, PRE, 2'd2, 13'h0000);  chk("R3 precharge", pulses, P_PRE);
    chk("R7 single close", bank_open, 4'b0001);
    issue(1'b0, ACT, 2'd3, 13'h0011);
    issue(1'b0, PRE, 2'd1, A10);       chk("R7 close all", bank_open, 4'b0000);
    issue(1'b0, REF, 2'd0, 13'h0000);  chk("R3 refresh", pulses, P_REF);
  endtask

  task automatic t_burst();
    issue(1'b0, ACT, 2'd1, 13'h0007);
    issue(1'b0, RD, 2'd1, 13'h01F3);   chk("R5 read pulse", pulses, P_RD);
    chk("R5 column", burst_col, 9'h1F3);
    chk("R5 burst on", burst_active, 1);
    for (int i = 0; i < 3; i++) begin nop(); chk("R5 burst held", burst_active, 1); end
    nop(); chk("R5 burst end", burst_active, 0);
    chk("R6 no close without flag", bank_open, 4'b0010);
    issue(1'b0, WR, 2'd1, A10 | 13'h0022); chk("R5 write pulse", pulses, P_WR);
    chk("R6 close pending", burst_autopre, 1);
    for (int i = 0; i < 3; i++) begin nop(); chk("R6 bank open mid burst", bank_open, 4'b0010); end
    nop(); chk("R6 auto close", bank_open, 4'b0000);
    chk("R6 burst end", burst_active, 0);
  endtask

  task automatic t_deselect();
    issue(1'b0, ACT, 2'd3, 13'h0009);
    issue(1'b0, RD, 2'd3, 13'h0004);
    for (int i = 0; i < 3; i++) begin
      issue(1'b1, ACT, 2'd0, 13'h0001);
      chk("R2 ignored", {pulses, err_p}, 0);
      chk("R2 burst continues", burst_active, 1);
    end
    issue(1'b1, REF, 2'd0, 13'h0000);
    chk("R2 burst ran out", burst_active, 0);
    chk("R2 banks unchanged", bank_open, 4'b1000);
    close_all();
  endtask

  task automatic t_errors();
    issue(1'b0, RD, 2'd2, 13'h0000);   chk("R8 read closed", {pulses, err_p}, 1);
    chk("R8 no burst", burst_active, 0);
    issue(1'b0, ACT, 2'd2, 13'h0001);
    issue(1'b0, ACT, 2'd2, 13'h0002);  chk("R8 double activate", {pulses, err_p}, 1);
    chk("R8 row kept", open_rows[26 +: 13], 13'h0001);
    issue(1'b0, WR, 2'd0, 13'h0000);   chk("R8 write closed", err_p, 1);
    issue(1'b0, REF, 2'd0, 13'h0000);  chk("R9 refresh open", {pulses, err_p}, 1);
    close_all();
  endtask

  task automatic t_ap_block();
    issue(1'b0, ACT, 2'd0, 13'h0003);
    issue(1'b0, RD, 2'd0, A10 | 13'h0010);
    issue(1'b0, WR, 2'd0, 13'h0020);   chk("R12 rejected", {pulses, err_p}, 1);
    chk("R12 column kept", burst_col, 9'h010);
    nop(); nop(); chk("R12 burst kept", burst_active, 1);
    nop(); chk("R12 close done", {burst_active, bank_open}, 0);
  endtask

  task automatic t_powerdown();
    issue(1'b0, ACT, 2'd1, 13'h0003);
    issue(1'b0, RD, 2'd1, 13'h0000);
    issue(1'b0, NOP, 2'd0, 13'h0, 1'b0);
    chk("R10 enter", {low_power, self_refresh}, 2'b10);
    for (int i = 0; i < 5; i++) begin
      issue(1'b0, ACT, 2'd2, 13'h0004, 1'b0);
      chk("R10 ignored", {pulses, err_p, bank_open}, 11'b0000000_0010);
      chk("R10 burst frozen", burst_active, 1);
    end
    issue(1'b0, ACT, 2'd2, 13'h0004);  chk("R10 exit", low_power, 0);
    chk("R10 exit command ignored", bank_open, 4'b0010);
    for (int i = 0; i < 3; i++) begin nop(); chk("R10 burst resumed", burst_active, 1); end
    nop(); chk("R10 burst end", burst_active, 0);
    close_all();
  endtask

  task automatic t_selfref();
    issue(1'b0, REF, 2'd0, 13'h0, 1'b0);
    chk("R11 self refresh", {low_power, self_refresh}, 2'b11);
    chk("R11 no pulse", {pulses, err_p}, 0);
    issue(1'b1, NOP, 2'd0, 13'h0, 1'b0); chk("R11 stays", self_refresh, 1);
    nop(); chk("R11 exit", {low_power, self_refresh}, 0);
    issue(1'b0, ACT, 2'd0, 13'h0008);
    issue(1'b0, REF, 2'd0, 13'h0, 1'b0);
    chk("R11 open bank power-down", {low_power, self_refresh, err_p}, 3'b101);
    nop();
    close_all();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_burst();
    t_deselect();
    t_errors();
    t_ap_block();
    t_powerdown();
    t_selfref();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule